// File: doc/BRIEF.md
# Host VRAM Access Port

This block sits between a host CPU and the video memory of a tile-based video controller. The host reaches it through two byte-wide windows. The index window selects one of the controller's internal 16-bit registers. The data window carries a register's value as a low byte and then a high byte. A low-byte write only stages that byte. The high-byte write completes the word and triggers whatever the selected register does.

Two registers hold independent write and read pointers into VRAM. A third register is the data latch. Writing it queues a one-word VRAM write at the write pointer. Reading it returns a word that was fetched ahead of time from the read pointer. Each pointer advances after a high-byte access to the latch, by a stride that the control register selects. The VRAM side uses a single request/acknowledge handshake. The host sees a busy bit in the status byte while any access it started is still queued or outstanding.

The block does not render, move blocks or raise interrupts. It hands the current stride and every committed configuration word to the parts of the controller that do.

Top module: `vram_host_port`

## Requirements
- R1: After reset the selected index is 0, both pointers are 0, the stride is 1 and the status byte reads 0x00. A low-byte write to the index window sets the 5-bit index from data bits 4:0.
- R2: A low-byte write to the data window only stages the byte. It issues no VRAM access, no configuration pulse and no pointer change.
- R3: A high-byte data write at index 0 loads the write pointer, and one at index 1 loads the read pointer. The loaded value is {high byte, staged low byte}.
- R4: A high-byte data write at index 2 issues exactly one VRAM write (vram_we_o=1) of {high byte, staged low byte} to the current write pointer. The write pointer then advances by the stride.
- R5: Loading the read pointer issues a VRAM read at the new address. Once the read completes, index 2 data reads return that word: bits 7:0 on a low-byte read and bits 15:8 on a high-byte read.
- R6: A high-byte data read at index 2 advances the read pointer by the stride and fetches the word at the new address. A low-byte read has no side effect.
- R7: The stride comes from bits 12:11 of the word written at index 5: 00 gives 1, 01 gives 32, 10 gives 64 and 11 gives 128. It is driven on step_o.
- R8: Both pointers wrap modulo 2^16 when they advance.
- R9: A read of the index window's low byte returns status with bit 6 = busy and all other bits 0. Busy is high from the cycle after an access is started until its VRAM acknowledge. A read of the index window's high byte returns 0.
- R10: High-byte data writes at indices 3, 4 and 20 to 31 are ignored. They cause no VRAM access, no configuration pulse and no change to the pointers or the stride.
- R11: A high-byte data write at indices 5 to 19 drives cfg_wr_o high for one cycle, with cfg_idx_o set to the index and cfg_data_o set to the assembled word.
- R12: Data reads at any index other than 2 return 0x00.
- R13: Once vram_req_o is raised, it stays high with stable address, direction and write data until vram_ack_i is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Host write strobe, one cycle per byte |
| bus_re_i | input | 1 | Host read strobe, one cycle per byte |
| bus_port_i | input | 1 | 0 selects the index/status window, 1 selects the data window |
| bus_hi_i | input | 1 | 1 selects the high byte |
| bus_wdata_i | input | 8 | Host write byte |
| bus_rdata_o | output | 8 | Host read byte, combinational |
| step_o | output | 16 | Current pointer stride |
| cfg_wr_o | output | 1 | Committed write pulse for indices 5 to 19 |
| cfg_idx_o | output | 5 | Index of the committed word |
| cfg_data_o | output | 16 | Committed word |
| vram_req_o | output | 1 | VRAM access request |
| vram_we_o | output | 1 | 1 = write, 0 = read |
| vram_addr_o | output | 16 | VRAM word address |
| vram_wdata_o | output | 16 | VRAM write data |
| vram_ack_i | input | 1 | VRAM acknowledge, completes the request |
| vram_rdata_i | input | 16 | VRAM read data, valid with the acknowledge |

## Verification
The bench builds the block with its default parameters: 16-bit address and data, a 5-bit index and 20 registers. This makes every index value and every stride sweepable in full. The bench covers all four strides at start addresses that include one just below 0xFFFF, so carries past the top of the address space are checked arithmetically. The VRAM model returns a word computed from the address and acknowledges after a latency that changes with the stride. This exercises the busy bit and the request hold across waits of zero to three cycles.

// File: rtl/vram_host_port_pkg.sv
package vram_host_port_pkg;
  localparam int unsigned REG_WPTR   = 0;
  localparam int unsigned REG_RPTR   = 1;
  localparam int unsigned REG_LATCH  = 2;
  localparam int unsigned REG_RSVD_A = 3;
  localparam int unsigned REG_RSVD_B = 4;
  localparam int unsigned REG_CTRL   = 5;
  localparam int unsigned STRIDE_LSB = 11;
  localparam int unsigned BUSY_BIT   = 6;

  typedef enum logic [1:0] {STR_1, STR_32, STR_64, STR_128} stride_e;

  function automatic int unsigned stride_shift(stride_e s);
    case (s)
      STR_1:   return 0;
      STR_32:  return 5;
      STR_64:  return 6;
      default: return 7;
    endcase
  endfunction
endpackage

// File: rtl/vram_host_regs.sv
module vram_host_regs
  import vram_host_port_pkg::*;
#(
  parameter int unsigned AW       = 16,
  parameter int unsigned IDX_W    = 5,
  parameter int unsigned NUM_REGS = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             re_i,
  input  logic             port_i,
  input  logic             hi_i,
  input  logic [7:0]       wdata_i,
  output logic [7:0]       rdata_o,
  input  logic             busy_i,
  input  logic [15:0]      latch_i,
  output logic [AW-1:0]    step_o,
  output logic             cfg_wr_o,
  output logic [IDX_W-1:0] cfg_idx_o,
  output logic [15:0]      cfg_data_o,
  output logic             wr_commit_o,
  output logic [AW-1:0]    wr_addr_o,
  output logic [15:0]      wr_data_o,
  output logic             rd_start_o,
  output logic [AW-1:0]    rd_ptr_o
);
  logic [IDX_W-1:0] idx_q;
  logic [7:0]       stage_q;
  logic [AW-1:0]    wr_ptr_q, rd_ptr_q;
  stride_e          stride_q;
  logic [15:0]      word;
  logic             hi_wr, hi_rd, idx_wr, is_rsvd, is_cfg;
  logic [7:0]       unused_idx_bits;

  assign unused_idx_bits = wdata_i;
  assign word    = {wdata_i, stage_q};
  assign hi_wr   = we_i && port_i && hi_i;
  assign hi_rd   = re_i && port_i && hi_i;
  assign idx_wr  = we_i && !port_i && !hi_i;
  assign is_rsvd = (int'(idx_q) == REG_RSVD_A) || (int'(idx_q) == REG_RSVD_B) ||
                   (int'(idx_q) >= NUM_REGS);
  assign is_cfg  = (int'(idx_q) >= REG_CTRL) && (int'(idx_q) < NUM_REGS);

  assign step_o      = AW'(1) << stride_shift(stride_q);
  assign wr_commit_o = hi_wr && (int'(idx_q) == REG_LATCH);
  assign wr_addr_o   = wr_ptr_q;
  assign wr_data_o   = word;
  assign rd_start_o  = (hi_wr && (int'(idx_q) == REG_RPTR)) ||
                       (hi_rd && (int'(idx_q) == REG_LATCH));
  assign rd_ptr_o    = rd_ptr_q;
  assign cfg_wr_o    = hi_wr && is_cfg;
  assign cfg_idx_o   = idx_q;
  assign cfg_data_o  = word;

  always_comb begin
    rdata_o = 8'h00;
    if (!port_i) begin
      if (!hi_i) rdata_o[BUSY_BIT] = busy_i;
    end else if (int'(idx_q) == REG_LATCH) begin
      rdata_o = hi_i ? latch_i[15:8] : latch_i[7:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q    <= '0;
      stage_q  <= '0;
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      stride_q <= STR_1;
    end else begin
      if (idx_wr) idx_q <= wdata_i[IDX_W-1:0];
      if (we_i && port_i && !hi_i) stage_q <= wdata_i;
      if (hi_wr && !is_rsvd) begin
        case (int'(idx_q))
          REG_WPTR:  wr_ptr_q <= AW'(word);
          REG_RPTR:  rd_ptr_q <= AW'(word);
          REG_LATCH: wr_ptr_q <= wr_ptr_q + step_o;
          REG_CTRL:  stride_q <= stride_e'(word[STRIDE_LSB+:2]);
          default: ;
        endcase
      end
      if (hi_rd && (int'(idx_q) == REG_LATCH)) rd_ptr_q <= rd_ptr_q + step_o;
    end
  end

  a_r4_wr_ptr_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_commit_o |=> wr_ptr_q == $past(wr_ptr_q) + $past(step_o));
  a_r6_rd_ptr_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_rd && int'(idx_q) == REG_LATCH) |=> rd_ptr_q == $past(rd_ptr_q) + $past(step_o));
  a_r10_rsvd_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_wr && is_rsvd) |=> ($stable(wr_ptr_q) && $stable(rd_ptr_q) && $stable(stride_q)));
  a_r7_step_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(step_o) == 1);
  a_r2_stage_no_effect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && port_i && !hi_i) |=> ($stable(wr_ptr_q) && $stable(rd_ptr_q)));
endmodule

// File: rtl/vram_access_seq.sv
module vram_access_seq #(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_commit_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_start_i,
  input  logic [AW-1:0] rd_ptr_i,
  output logic          busy_o,
  output logic [DW-1:0] latch_o,
  output logic          vram_req_o,
  output logic          vram_we_o,
  output logic [AW-1:0] vram_addr_o,
  output logic [DW-1:0] vram_wdata_o,
  input  logic          vram_ack_i,
  input  logic [DW-1:0] vram_rdata_i
);
  logic          wr_pend_q, rd_pend_q, act_q, op_we_q;
  logic [AW-1:0] wr_addr_q, op_addr_q;
  logic [DW-1:0] wr_data_q, op_data_q, latch_q;

  assign busy_o       = wr_pend_q || rd_pend_q || act_q;
  assign latch_o      = latch_q;
  assign vram_req_o   = act_q;
  assign vram_we_o    = op_we_q;
  assign vram_addr_o  = op_addr_q;
  assign vram_wdata_o = op_data_q;

  // writes launch before reads so a fetch after a store sees the new word
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_pend_q <= 1'b0;
      rd_pend_q <= 1'b0;
      act_q     <= 1'b0;
      op_we_q   <= 1'b0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
      op_addr_q <= '0;
      op_data_q <= '0;
      latch_q   <= '0;
    end else begin
      if (act_q) begin
        if (vram_ack_i) begin
          act_q <= 1'b0;
          if (!op_we_q) latch_q <= vram_rdata_i;
        end
      end else if (wr_pend_q) begin
        act_q     <= 1'b1;
        op_we_q   <= 1'b1;
        op_addr_q <= wr_addr_q;
        op_data_q <= wr_data_q;
        wr_pend_q <= 1'b0;
      end else if (rd_pend_q) begin
        act_q     <= 1'b1;
        op_we_q   <= 1'b0;
        op_addr_q <= rd_ptr_i;
        rd_pend_q <= 1'b0;
      end
      if (wr_commit_i) begin
        wr_pend_q <= 1'b1;
        wr_addr_q <= wr_addr_i;
        wr_data_q <= wr_data_i;
      end
      if (rd_start_i) rd_pend_q <= 1'b1;
    end
  end

  a_r13_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vram_req_o && !vram_ack_i) |=> (vram_req_o && $stable(vram_addr_o) &&
                                     $stable(vram_we_o) && $stable(vram_wdata_o)));
  a_r9_busy_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_commit_i || rd_start_i) |=> busy_o);
  a_r9_busy_while_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vram_req_o |-> busy_o);
endmodule

// File: rtl/vram_host_port.sv
module vram_host_port #(
  parameter int unsigned AW       = 16,
  parameter int unsigned IDX_W    = 5,
  parameter int unsigned NUM_REGS = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_we_i,
  input  logic             bus_re_i,
  input  logic             bus_port_i,
  input  logic             bus_hi_i,
  input  logic [7:0]       bus_wdata_i,
  output logic [7:0]       bus_rdata_o,
  output logic [AW-1:0]    step_o,
  output logic             cfg_wr_o,
  output logic [IDX_W-1:0] cfg_idx_o,
  output logic [15:0]      cfg_data_o,
  output logic             vram_req_o,
  output logic             vram_we_o,
  output logic [AW-1:0]    vram_addr_o,
  output logic [15:0]      vram_wdata_o,
  input  logic             vram_ack_i,
  input  logic [15:0]      vram_rdata_i
);
  localparam int unsigned DW = 16;

  logic          busy, wr_commit, rd_start;
  logic [DW-1:0] latch, wr_data;
  logic [AW-1:0] wr_addr, rd_ptr;

  vram_host_regs #(.AW(AW), .IDX_W(IDX_W), .NUM_REGS(NUM_REGS)) regs_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (bus_we_i),
    .re_i        (bus_re_i),
    .port_i      (bus_port_i),
    .hi_i        (bus_hi_i),
    .wdata_i     (bus_wdata_i),
    .rdata_o     (bus_rdata_o),
    .busy_i      (busy),
    .latch_i     (latch),
    .step_o      (step_o),
    .cfg_wr_o    (cfg_wr_o),
    .cfg_idx_o   (cfg_idx_o),
    .cfg_data_o  (cfg_data_o),
    .wr_commit_o (wr_commit),
    .wr_addr_o   (wr_addr),
    .wr_data_o   (wr_data),
    .rd_start_o  (rd_start),
    .rd_ptr_o    (rd_ptr)
  );

  vram_access_seq #(.AW(AW), .DW(DW)) seq_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_commit_i  (wr_commit),
    .wr_addr_i    (wr_addr),
    .wr_data_i    (wr_data),
    .rd_start_i   (rd_start),
    .rd_ptr_i     (rd_ptr),
    .busy_o       (busy),
    .latch_o      (latch),
    .vram_req_o   (vram_req_o),
    .vram_we_o    (vram_we_o),
    .vram_addr_o  (vram_addr_o),
    .vram_wdata_o (vram_wdata_o),
    .vram_ack_i   (vram_ack_i),
    .vram_rdata_i (vram_rdata_i)
  );
endmodule

// File: tb/vram_host_port_tb_top.sv
`timescale 1ns/1ps
module vram_host_port_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_we_i = 1'b0, bus_re_i = 1'b0, bus_port_i = 1'b0, bus_hi_i = 1'b0;
  logic [7:0]  bus_wdata_i = '0;
  logic [7:0]  bus_rdata_o;
  logic [15:0] step_o;
  logic        cfg_wr_o;
  logic [4:0]  cfg_idx_o;
  logic [15:0] cfg_data_o;
  logic        vram_req_o, vram_we_o;
  logic [15:0] vram_addr_o, vram_wdata_o;
  logic        vram_ack_i = 1'b0;
  logic [15:0] vram_rdata_i;

  int checks = 0, fails = 0;
  int lat = 0, lat_cnt = 0;
  int wr_cnt = 0, rd_cnt = 0, cfg_cnt = 0, hold_err = 0;
  logic [15:0] last_wa, last_wd, prev_addr;
  logic [4:0]  last_ci;
  logic [15:0] last_cd;
  logic        prev_wait = 1'b0;
  bit          done = 1'b0;

  always #2 clk_i = ~clk_i;

  vram_host_port dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .bus_we_i(bus_we_i), .bus_re_i(bus_re_i),
    .bus_port_i(bus_port_i), .bus_hi_i(bus_hi_i), .bus_wdata_i(bus_wdata_i),
    .bus_rdata_o(bus_rdata_o), .step_o(step_o), .cfg_wr_o(cfg_wr_o),
    .cfg_idx_o(cfg_idx_o), .cfg_data_o(cfg_data_o), .vram_req_o(vram_req_o),
    .vram_we_o(vram_we_o), .vram_addr_o(vram_addr_o), .vram_wdata_o(vram_wdata_o),
    .vram_ack_i(vram_ack_i), .vram_rdata_i(vram_rdata_i)
  );

  function automatic logic [15:0] pat(input logic [15:0] a);
    return {a[7:0], a[15:8]} ^ 16'h3C5A;
  endfunction
  function automatic logic [15:0] stride(input int s);
    return (s == 0) ? 16'd1 : 16'(1 << (s + 4));
  endfunction

  assign vram_rdata_i = pat(vram_addr_o);

  // VRAM model and monitors
  always @(posedge clk_i) begin
    if (vram_req_o && vram_ack_i) begin
      if (vram_we_o) begin wr_cnt++; last_wa = vram_addr_o; last_wd = vram_wdata_o; end
      else rd_cnt++;
    end
    if (prev_wait && (!vram_req_o || vram_addr_o != prev_addr)) hold_err++;
    prev_wait = vram_req_o && !vram_ack_i;
    prev_addr = vram_addr_o;
    if (cfg_wr_o) begin cfg_cnt++; last_ci = cfg_idx_o; last_cd = cfg_data_o; end
    if (vram_req_o && !vram_ack_i) begin
      if (lat_cnt >= lat) begin vram_ack_i <= 1'b1; lat_cnt = 0; end
      else lat_cnt++;
    end else vram_ack_i <= 1'b0;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  task automatic bus_wr(input logic port, input logic hi, input logic [7:0] d);
    @(negedge clk_i);
    bus_we_i = 1'b1; bus_port_i = port; bus_hi_i = hi; bus_wdata_i = d;
    @(posedge clk_i); #1;
    bus_we_i = 1'b0;
  endtask

  task automatic bus_rd(input logic port, input logic hi, output logic [7:0] d);
    @(negedge clk_i);
    bus_re_i = 1'b1; bus_port_i = port; bus_hi_i = hi;
    #1 d = bus_rdata_o;
    @(posedge clk_i); #1;
    bus_re_i = 1'b0;
  endtask

  task automatic set_idx(input int i);
    bus_wr(1'b0, 1'b0, 8'(i));
  endtask

  task automatic wr_word(input int i, input logic [15:0] w);
    set_idx(i);
    bus_wr(1'b1, 1'b0, w[7:0]);
    bus_wr(1'b1, 1'b1, w[15:8]);
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    int n = 0;
    s = 8'h40;
    while (s[6] && n < 100) begin bus_rd(1'b0, 1'b0, s); n++; end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++; checks++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [7:0] d;
    logic [15:0] exp_a, wp_end;
    int w0, c0;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;

    // R1 reset state, R9 idle status, R12 data read at index 0
    bus_rd(1'b0, 1'b0, d); chk(d == 8'h00, "R1 R9 status after reset", d, 0);
    bus_rd(1'b0, 1'b1, d); chk(d == 8'h00, "R9 status high byte", d, 0);
    chk(step_o == 16'd1, "R1 stride after reset", step_o, 1);
    bus_rd(1'b1, 1'b0, d); chk(d == 8'h00, "R12 data read index 0", d, 0);
    set_idx(2); bus_wr(1'b1, 1'b0, 8'h11); bus_wr(1'b1, 1'b1, 8'h22); wait_idle();
    chk(wr_cnt == 1 && last_wa == 16'h0000, "R1 write pointer reset value", last_wa, 0);
    chk(last_wd == 16'h2211, "R4 assembled write word", last_wd, 16'h2211);

    // R7 stride select, R11 config pulse at index 5
    for (int s = 0; s < 4; s++) begin
      c0 = cfg_cnt;
      wr_word(5, 16'(s << 11) | 16'h00A5);
      chk(step_o == stride(s), "R7 stride select", step_o, stride(s));
      chk(cfg_cnt == c0 + 1 && last_ci == 5'd5, "R11 control pulse", cfg_cnt - c0, 1);
    end

    // R3 R4 R5 R6 R8 sweep over strides and start addresses
    for (int s = 0; s < 4; s++) begin
      lat = s;
      wr_word(5, 16'(s << 11));
      for (int b = 0; b < 3; b++) begin
        logic [15:0] st;
        st = (b == 0) ? 16'h0000 : (b == 1) ? 16'h1234 : 16'hFFC0;
        wr_word(0, st);
        set_idx(2);
        for (int k = 0; k < 3; k++) begin
          exp_a = st + 16'(k) * stride(s);
          w0 = wr_cnt;
          bus_wr(1'b1, 1'b0, 8'(k + 16 * s));
          @(negedge clk_i); @(negedge clk_i);
          chk(wr_cnt == w0 && !vram_req_o, "R2 low byte stages only", wr_cnt - w0, 0);
          bus_wr(1'b1, 1'b1, 8'(b));
          wait_idle();
          chk(wr_cnt == w0 + 1, "R4 one write per commit", wr_cnt - w0, 1);
          chk(last_wa == exp_a, "R3 R4 R8 write address", last_wa, exp_a);
          chk(last_wd == {8'(b), 8'(k + 16 * s)}, "R4 write data", last_wd, {8'(b), 8'(k + 16 * s)});
        end
        wr_word(1, st);
        wait_idle();
        set_idx(2);
        for (int k = 0; k < 3; k++) begin
          exp_a = st + 16'(k) * stride(s);
          bus_rd(1'b1, 1'b0, d);
          chk(d == pat(exp_a)[7:0], "R5 R8 latch low byte", d, pat(exp_a)[7:0]);
          bus_rd(1'b1, 1'b0, d);
          chk(d == pat(exp_a)[7:0], "R6 low read no advance", d, pat(exp_a)[7:0]);
          bus_rd(1'b1, 1'b1, d);
          chk(d == pat(exp_a)[15:8], "R5 latch high byte", d, pat(exp_a)[15:8]);
          wait_idle();
        end
      end
    end

    // R9 busy visible while a slow write is pending
    lat = 3;
    wr_word(5, 16'h0000);
    wr_word(0, 16'h4000);
    set_idx(2); bus_wr(1'b1, 1'b0, 8'h01); bus_wr(1'b1, 1'b1, 8'h02);
    bus_rd(1'b0, 1'b0, d); chk(d == 8'h40, "R9 busy after commit", d, 8'h40);
    bus_rd(1'b0, 1'b1, d); chk(d == 8'h00, "R9 high status byte", d, 0);
    wait_idle();
    bus_rd(1'b0, 1'b0, d); chk(d == 8'h00, "R9 busy clears after ack", d, 0);
    wp_end = 16'h4001;

    // R10 reserved indices ignored, R12 zero reads
    for (int i = 3; i < 32; i++) begin
      if (i == 5) i = 20;
      w0 = wr_cnt + rd_cnt; c0 = cfg_cnt;
      wr_word(i, 16'hFFFF);
      @(negedge clk_i); @(negedge clk_i);
      chk(wr_cnt + rd_cnt == w0 && !vram_req_o, "R10 no VRAM access", wr_cnt + rd_cnt - w0, 0);
      chk(cfg_cnt == c0 && step_o == 16'd1, "R10 no config effect", cfg_cnt - c0, 0);
      bus_rd(1'b1, 1'b1, d); chk(d == 8'h00, "R12 data read non-latch index", d, 0);
    end
    set_idx(2); bus_wr(1'b1, 1'b0, 8'h33); bus_wr(1'b1, 1'b1, 8'h44); wait_idle();
    chk(last_wa == wp_end, "R10 write pointer kept", last_wa, wp_end);

    // R11 config pulse sweep over indices 6..19
    for (int i = 6; i < 20; i++) begin
      c0 = cfg_cnt;
      wr_word(i, {8'(i), ~8'(i)});
      chk(cfg_cnt == c0 + 1 && last_ci == 5'(i), "R11 config index", last_ci, i);
      chk(last_cd == {8'(i), ~8'(i)}, "R11 config data", last_cd, {8'(i), ~8'(i)});
    end

    chk(hold_err == 0, "R13 request held until ack", hold_err, 0);
    repeat (4) @(posedge clk_i);
    summary();
  end
endmodule